// File: doc/BRIEF.md
# Successive Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation analogue-to-digital converter. Software starts a conversion by pulsing a start request while the converter is enabled. The block latches the requested input channel and presents it to an external analogue multiplexer. It divides the system clock down to a slower conversion tick. After an optional settling delay, it runs a binary search. On each step it drives a trial code to an external DAC and samples an external comparator.

When the last bit is decided, the 10-bit code is written into a 16-bit result pair, either left-aligned or right-aligned. The busy indication drops on that same edge and a sticky completion flag is raised. The sample-and-hold, DAC and comparator are outside the block. The comparator input must read 1 when the sampled input is at or above the trial level on `dac_code`.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `busy`, `done_flag`, `dac_code`, `chan_out`, `res_hi` and `res_lo` are all zero.
- R2: The search decides bits MSB first. A trial bit is kept when `cmp_in` is 1 and dropped otherwise, so an input at code V (0..1023) converts to exactly V.
- R3: The first trial code driven after the settling delay is 0x200. Every later trial code is the bits kept so far with the bit under test also set.
- R4: The tick period is 2 system clocks for `clk_div_sel` 00, 8 for 01, and 32 for both 10 and 11. With settling delay S, `busy` stays high for exactly (S+10) tick periods from the edge that accepts the start.
- R5: A `go_set` pulse has no effect while `enable` is low or while `busy` is high. The running conversion keeps its timing, channel and result.
- R6: `busy` rises on the edge that accepts a start. It falls on the same edge that loads the result and raises `done_flag`.
- R7: `done_flag` stays set until `flag_clr` is high at an edge. If completion and `flag_clr` coincide, the flag is set.
- R8: With `justify` = 0 at start, `res_hi` = code[9:2] and `res_lo` = {code[1:0], 000000}. With `justify` = 1, `res_hi` = {000000, code[9:8]} and `res_lo` = code[7:0].
- R9: `chan_out` takes the value of `chan_sel` on the accepting edge and holds it for the whole conversion, whatever `chan_sel` does meanwhile.
- R10: For the settling delay S (`settle_len`, 0..15), `dac_code` stays 0 for S tick periods before the first trial.
- R11: `res_hi` and `res_lo` keep their previous values throughout a conversion until the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; starts are refused while low |
| go_set | input | 1 | Start request, sampled at each rising edge |
| clk_div_sel | input | 2 | Tick divider select (00:/2, 01:/8, 10 and 11:/32) |
| chan_sel | input | 3 | Requested input channel |
| justify | input | 1 | Result placement: 0 left, 1 right |
| settle_len | input | 4 | Settling delay in ticks before the MSB trial |
| flag_clr | input | 1 | Clears the completion flag |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial level |
| dac_code | output | 10 | Trial code for the external DAC, 0 when not trialling |
| chan_out | output | 3 | Channel latched for the current conversion |
| busy | output | 1 | Conversion in progress (self-clearing start bit) |
| done_flag | output | 1 | Sticky completion flag |
| res_hi | output | 8 | High byte of the result pair |
| res_lo | output | 8 | Low byte of the result pair |

## Verification
The start pulse is driven between edges, so the accepting edge is the next rising edge. `busy` is then seen high on exactly (S+10)·D consecutive falling edges, where D is the tick period. The bench counts those falling edges rather than waiting a fixed time. Over the same window it counts falling edges with `dac_code` at zero, expecting S·D, and records the first nonzero trial, which must be 0x200.

The result pair, `done_flag` and `chan_out` are checked at the first falling edge after `busy` drops. For the coincident-clear case, the flag is checked one further cycle later, when the clear takes hold. Refused starts are observed over fifty idle cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned CODE_W = 10;
  localparam int unsigned PAIR_W = 16;
  localparam int unsigned PAD_W  = PAIR_W - CODE_W;
  localparam int unsigned DIVCNT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_TRIAL  = 2'd2
  } sar_state_e;

  // Tick period in system clocks for a divider select code; 11 aliases 10.
  function automatic logic [DIVCNT_W:0] tick_period(input logic [1:0] sel);
    logic [DIVCNT_W:0] p;
    unique case (sel)
      2'b00:   p = 6'd2;
      2'b01:   p = 6'd8;
      default: p = 6'd32;
    endcase
    return p;
  endfunction

  // Places a code inside the result pair.
  function automatic logic [PAIR_W-1:0] place_code(input logic [CODE_W-1:0] code,
                                                   input logic right_align);
    logic [PAIR_W-1:0] w;
    if (right_align) w = {{PAD_W{1'b0}}, code};
    else             w = {code, {PAD_W{1'b0}}};
    return w;
  endfunction

endpackage

// File: rtl/sar_prescale.sv
module sar_prescale
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);

  logic [DIVCNT_W-1:0] cnt_q;
  logic [DIVCNT_W:0]   period;
  logic [DIVCNT_W-1:0] last_val;

  assign period   = tick_period(div_sel);
  assign last_val = DIVCNT_W'(period - 1'b1);
  assign tick     = !restart && (cnt_q == last_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the shortest tick period is two clocks, so ticks never abut.
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_pkg::*;
#(
  parameter int unsigned N        = CODE_W,
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                tick,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                cmp_in,
  output logic [N-1:0]        dac_code,
  output logic                active,
  output logic                finish,
  output logic [N-1:0]        code_out
);

  localparam int unsigned IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N - 1);

  sar_state_e          state_q;
  logic [SETTLE_W-1:0] wait_q;
  logic [IDX_W-1:0]    idx_q;
  logic [N-1:0]        kept_q;
  logic [N-1:0]        probe;
  logic                settle_end;

  assign probe      = N'(1) << idx_q;
  assign active     = (state_q != ST_IDLE);
  assign dac_code   = (state_q == ST_TRIAL) ? (kept_q | probe) : '0;
  assign settle_end = (state_q == ST_SETTLE) && tick && (wait_q == SETTLE_W'(1));
  assign finish     = (state_q == ST_TRIAL) && tick && (idx_q == '0);
  assign code_out   = cmp_in ? (kept_q | probe) : kept_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      idx_q   <= '0;
      kept_q  <= '0;
    end else if (start) begin
      wait_q  <= settle_len;
      idx_q   <= TOP_IDX;
      kept_q  <= '0;
      state_q <= (settle_len == '0) ? ST_TRIAL : ST_SETTLE;
    end else if (tick) begin
      unique case (state_q)
        ST_SETTLE: begin
          wait_q <= wait_q - 1'b1;
          if (wait_q == SETTLE_W'(1)) state_q <= ST_TRIAL;
        end
        ST_TRIAL: begin
          if (cmp_in) kept_q <= kept_q | probe;
          if (idx_q == '0) state_q <= ST_IDLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3: the first trial after settling probes the MSB alone.
  p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    settle_end |=> (dac_code == (N'(1) << (N - 1))));

endmodule

// File: rtl/sar_result.sv
module sar_result
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              right_align,
  output logic [7:0]        res_hi,
  output logic [7:0]        res_lo
);

  logic [PAIR_W-1:0] pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pair_q <= '0;
    else if (load) pair_q <= place_code(code, right_align);
  end

  assign res_hi = pair_q[PAIR_W-1:8];
  assign res_lo = pair_q[7:0];

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              go_set,
  input  logic [1:0]        clk_div_sel,
  input  logic [2:0]        chan_sel,
  input  logic              justify,
  input  logic [3:0]        settle_len,
  input  logic              flag_clr,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] dac_code,
  output logic [2:0]        chan_out,
  output logic              busy,
  output logic              done_flag,
  output logic [7:0]        res_hi,
  output logic [7:0]        res_lo
);

  logic              accept;
  logic              tick;
  logic              finish;
  logic [CODE_W-1:0] code;
  logic [1:0]        div_q;
  logic              just_q;
  logic [2:0]        chan_q;
  logic              flag_q;

  assign accept = go_set && enable && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      just_q <= 1'b0;
      chan_q <= '0;
    end else if (accept) begin
      div_q  <= clk_div_sel;
      just_q <= justify;
      chan_q <= chan_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (finish)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  sar_prescale u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .div_sel (div_q),
    .tick    (tick)
  );

  sar_search #(.N(CODE_W), .SETTLE_W(4)) u_srch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .tick       (tick),
    .settle_len (settle_len),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .active     (busy),
    .finish     (finish),
    .code_out   (code)
  );

  sar_result u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (finish),
    .code        (code),
    .right_align (just_q),
    .res_hi      (res_hi),
    .res_lo      (res_lo)
  );

  assign chan_out  = chan_q;
  assign done_flag = flag_q;

  // R5: a start is refused while disabled.
  p_no_start_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy);

  // R6: the flag rises on the edge that ends the conversion.
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));

  // R7: the flag holds until cleared.
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  // R9: channel held for the whole conversion.
  p_chan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_out));

  // R11: result pair frozen while busy.
  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(res_hi) && $stable(res_lo)));

endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       go_set = 1'b0;
  logic [1:0] clk_div_sel = '0;
  logic [2:0] chan_sel = '0;
  logic       justify = 1'b0;
  logic [3:0] settle_len = '0;
  logic       flag_clr = 1'b0;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [2:0] chan_out;
  logic       busy;
  logic       done_flag;
  logic [7:0] res_hi;
  logic [7:0] res_lo;

  int vin = 0;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  // Comparator model: input at or above trial level reads 1.
  assign cmp_in = (vin >= int'(dac_code));

  sar_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .go_set(go_set),
    .clk_div_sel(clk_div_sel), .chan_sel(chan_sel), .justify(justify),
    .settle_len(settle_len), .flag_clr(flag_clr), .cmp_in(cmp_in),
    .dac_code(dac_code), .chan_out(chan_out), .busy(busy),
    .done_flag(done_flag), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int sel);
    if (sel == 0) return 2;
    if (sel == 1) return 8;
    return 32;
  endfunction

  task automatic run_conv(input int v, input int sel, input bit jst, input int stl,
                          input int ch, input bit poke, input bit clr_hold);
    int cyc = 0;
    int zeros = 0;
    int first_nz = -1;
    bit hold_ok = 1;
    bit chan_ok = 1;
    int prev_hi;
    int prev_lo;
    int ehi;
    int elo;
    int t_exp;
    vin = v;
    clk_div_sel = 2'(sel);
    justify = jst;
    settle_len = 4'(stl);
    chan_sel = 3'(ch);
    prev_hi = res_hi;
    prev_lo = res_lo;
    @(negedge clk);
    flag_clr = clr_hold;
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    while (busy && cyc < 5000) begin
      cyc++;
      if (dac_code == 0) zeros++;
      else if (first_nz < 0) first_nz = dac_code;
      if (res_hi != prev_hi || res_lo != prev_lo) hold_ok = 0;
      if (chan_out != 3'(ch)) chan_ok = 0;
      if (poke && cyc == 3) begin
        chan_sel = ~3'(ch);
        go_set = 1'b1;
      end
      if (poke && cyc == 4) go_set = 1'b0;
      @(negedge clk);
    end
    t_exp = (stl + 10) * period_of(sel);
    chk(cyc == t_exp, poke ? "R5 busy window with ignored start" : "R4 busy window", cyc, t_exp);
    chk(zeros == stl * period_of(sel), "R10 settle zeros", zeros, stl * period_of(sel));
    chk(first_nz == 512, "R3 first trial", first_nz, 512);
    chk(hold_ok, "R11 result hold", int'(hold_ok), 1);
    chk(chan_ok && chan_out == 3'(ch), poke ? "R9 channel hold" : "R9 channel latch", chan_out, ch);
    ehi = jst ? (v >> 8) : (v >> 2);
    elo = jst ? (v & 255) : ((v & 3) << 6);
    chk(res_hi == 8'(ehi), "R2/R8 high byte", res_hi, ehi);
    chk(res_lo == 8'(elo), "R2/R8 low byte", res_lo, elo);
    chk(done_flag == 1'b1, clr_hold ? "R7 set wins" : "R6 flag at completion", done_flag, 1);
    if (clr_hold) begin
      @(negedge clk);
      chk(done_flag == 1'b0, "R7 clear after set", done_flag, 0);
      flag_clr = 1'b0;
    end else begin
      repeat (5) @(negedge clk);
      chk(done_flag == 1'b1, "R7 sticky", done_flag, 1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(done_flag == 1'b0, "R7 cleared", done_flag, 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done_flag == 0 && dac_code == 0, "R1 reset ctrl", busy, 0);
    chk(chan_out == 0 && res_hi == 0 && res_lo == 0, "R1 reset regs", res_hi, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: start while disabled is ignored.
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    begin
      bit quiet = 1;
      for (int i = 0; i < 50; i++) begin
        if (busy || dac_code != 0 || done_flag) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R5 disabled start ignored", int'(quiet), 1);
    end
    enable = 1'b1;

    // R2, R8: exhaustive sweep of all codes at the fastest tick.
    for (int v = 0; v < 1024; v++) run_conv(v, 0, v[0], 0, v % 8, 1'b0, 1'b0);

    // R4, R10: every divider code with settling delays.
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        run_conv((s * 257 + d * 91) % 1024, d, d[0], s, s + d, 1'b0, 1'b0);
      end
    end
    run_conv(1023, 1, 1'b0, 15, 6, 1'b0, 1'b0);
    run_conv(0, 1, 1'b1, 15, 1, 1'b0, 1'b0);

    // R5, R9: start and channel change during a conversion.
    run_conv(700, 1, 1'b1, 2, 5, 1'b1, 1'b0);
    run_conv(3, 2, 1'b0, 1, 2, 1'b1, 1'b0);

    // R7: clear held across the completion edge.
    run_conv(512, 0, 1'b1, 0, 7, 1'b0, 1'b1);
    run_conv(511, 1, 1'b0, 3, 4, 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule